// File: doc/BRIEF.md
# Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds. On every reference clock cycle while it runs, it adds a small step to the count. The step is normally the default step. On chosen cycles a separate compensation step is added instead, so software can trim the effective frequency of the time base without ever stopping it. Two mechanisms pick those cycles. The first is a one-shot budget of compensated cycles. The second is a slow down-counter that triggers one compensated cycle per programmed period.

Software reaches the block through a single-cycle register port. Writes are strobed by `wr_en`. Reads use `rd_data`, which follows `addr` combinationally, and `rd_en` marks a read for its side effect. Reading the low count word captures the high word, so a pair of 32-bit reads gives a coherent 64-bit time. A compare-0 match input from a neighbouring compare unit can return the count to zero, which gives cyclic operation. A sticky flag reports a carry out of bit 63.

A two-state run controller with states `ST_HALT` and `ST_RUN` gates counting. The transition `ST_HALT -> ST_RUN` is taken when the run bit is set. The transition `ST_RUN -> ST_HALT` is taken when the run bit is clear. Otherwise the controller stays in its state. Each running cycle classifies its step as `INC_DEFAULT`, `INC_FAST` (a budget cycle) or `INC_SLOW` (a period expiry).

Top module: `nstime_counter`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, the controller is in `ST_HALT`, and address 0 reads 0x0000_0440: both steps are 4 and all enables are clear.
- R2: Config bit 0 is the run bit. After the write that sets it, the count first advances on the second rising edge. After the write that clears it, the count advances on exactly one more edge and then holds.
- R3: A carry out of bit 63 during an advance sets the overflow flag, which is seen on `ovf` and on address 1 bit 0. The flag stays set until a write to address 1 with bit 0 set. A set in the same cycle as a clear wins.
- R4: Address 0 holds the configuration: bit 0 run, bits 7:4 default step, bits 19:8 compensation step, bit 24 compare-reset enable. All other bits read 0. A running cycle with no compensation adds the default step.
- R5: Address 2 is the fast budget. A written value above 0xFFFFFF loads 0xFFFFFF. While the budget is nonzero, each running cycle adds the compensation step and lowers the budget by one. A read returns the remaining budget.
- R6: Address 3 is the slow period N. A write loads N into the down-counter. When N is nonzero, every N-th running cycle after the write adds the compensation step. A cycle that is both a budget cycle and an expiry adds the compensation step only once. A read returns N.
- R7: A slow period of 0 never produces a compensated cycle.
- R8: A write to address 4 loads the low half of the count at the next edge, and a write to address 5 loads the high half. The other half keeps its value, and the write overrides that cycle's step and any compare reset.
- R9: A read of address 4 with `rd_en` high returns the low 32 bits and captures the high 32 bits at that edge. A later read of address 5 returns the captured word.
- R10: When bit 24 is set and `cmp0_hit` is high in a running cycle, the count is 0 after that edge and the overflow flag does not change.
- R11: When bit 24 is clear, `cmp0_hit` has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a read of address 4 captures the high word |
| rd_data | output | 32 | Read data for `addr` |
| cmp0_hit | input | 1 | Compare-0 match from the compare unit |
| count | output | 64 | Current nanosecond count |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions check on every cycle that a halted counter holds its value, that an advance adds exactly the step chosen for that cycle, that the overflow flag stays set until it is cleared, and that an enabled compare hit zeroes the count. They also check that the budget counts down by one per running cycle, that the slow down-counter never exceeds its period, and that the captured high word matches the count at the capturing edge. Some behaviour needs scenarios in the bench. These are the two-edge latency of the run bit, the 0xFFFFFF clamp, the exact spacing of slow expiries, the coherence of a low/high read pair across a carry into the high word, and the fact that a hit is ignored when bit 24 is clear.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int REG_AW      = 3;
    localparam int REG_DW      = 32;
    localparam int DEF_W       = 4;
    localparam int COMP_W      = 12;
    localparam int CFG_RUN_BIT = 0;
    localparam int CFG_DEF_LSB = 4;
    localparam int CFG_CMP_LSB = 8;
    localparam int CFG_RST_BIT = 24;

    localparam logic [REG_AW-1:0] RA_CFG    = 3'd0;
    localparam logic [REG_AW-1:0] RA_STAT   = 3'd1;
    localparam logic [REG_AW-1:0] RA_FAST   = 3'd2;
    localparam logic [REG_AW-1:0] RA_SLOW   = 3'd3;
    localparam logic [REG_AW-1:0] RA_CNT_LO = 3'd4;
    localparam logic [REG_AW-1:0] RA_CNT_HI = 3'd5;

    typedef enum logic {ST_HALT, ST_RUN} run_state_e;
    typedef enum logic [1:0] {INC_DEFAULT, INC_FAST, INC_SLOW} inc_sel_e;

    typedef struct packed {
        logic              cmp0_rst;
        logic [COMP_W-1:0] comp_inc;
        logic [DEF_W-1:0]  def_inc;
        logic              run;
    } cfg_t;
endpackage

// File: rtl/tc_ctrl.sv
module tc_ctrl
    import tc_pkg::*;
#(
    parameter int DEF_INC_RST  = 4,
    parameter int COMP_INC_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              run_in,
    input  logic [DEF_W-1:0]  def_in,
    input  logic [COMP_W-1:0] comp_in,
    input  logic              rst_en_in,
    output cfg_t              cfg,
    output logic              running
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{cmp0_rst: 1'b0, comp_inc: COMP_W'(COMP_INC_RST),
                     def_inc: DEF_W'(DEF_INC_RST), run: 1'b0};
        end else if (cfg_wr) begin
            cfg <= '{cmp0_rst: rst_en_in, comp_inc: comp_in,
                     def_inc: def_in, run: run_in};
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (cfg.run)  state_d = ST_RUN;
            ST_RUN:  if (!cfg.run) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb running = (state_q == ST_RUN);

    // R2: a halted controller with the run bit clear stays halted
    p_halt_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !cfg.run) |=> !running);
endmodule

// File: rtl/tc_comp.sv
module tc_comp
    import tc_pkg::*;
#(
    parameter int FAST_W = 24,
    parameter int SLOW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              fast_wr,
    input  logic              slow_wr,
    input  logic [REG_DW-1:0] wdata,
    output logic [FAST_W-1:0] fast_q,
    output logic [SLOW_W-1:0] slow_period,
    output inc_sel_e          inc_sel
);
    localparam logic [FAST_W-1:0] FAST_MAX = '1;

    logic [SLOW_W-1:0] slow_cnt;
    logic [FAST_W-1:0] fast_load;
    logic              slow_expire;

    always_comb begin
        fast_load   = (wdata > REG_DW'(FAST_MAX)) ? FAST_MAX : wdata[FAST_W-1:0];
        slow_expire = running && (slow_period != '0) && (slow_cnt <= SLOW_W'(1));
        if (running && fast_q != '0) inc_sel = INC_FAST;
        else if (slow_expire)        inc_sel = INC_SLOW;
        else                         inc_sel = INC_DEFAULT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         fast_q <= '0;
        else if (fast_wr)                   fast_q <= fast_load;
        else if (running && fast_q != '0)   fast_q <= fast_q - FAST_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_period <= '0;
            slow_cnt    <= '0;
        end else if (slow_wr) begin
            slow_period <= wdata[SLOW_W-1:0];
            slow_cnt    <= wdata[SLOW_W-1:0];
        end else if (running && slow_period != '0) begin
            slow_cnt <= slow_expire ? slow_period : slow_cnt - SLOW_W'(1);
        end
    end

    p_fast_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && fast_q != '0 && !fast_wr) |=> fast_q == $past(fast_q) - FAST_W'(1));
    p_fast_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !fast_wr) |=> $stable(fast_q));
    p_slow_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_period != '0) |-> slow_cnt <= slow_period);
    p_slow_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_period == '0) |-> inc_sel != INC_SLOW);
endmodule

// File: rtl/tc_core.sv
module tc_core
    import tc_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int STEP_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                running,
    input  logic [STEP_W-1:0]   step,
    input  logic                cmp0_rst_en,
    input  logic                cmp0_hit,
    input  logic                lo_wr,
    input  logic                hi_wr,
    input  logic [HALF_W-1:0]   wdata,
    input  logic                ovf_clr,
    input  logic                snap,
    output logic [2*HALF_W-1:0] cnt_q,
    output logic                ovf_q,
    output logic [HALF_W-1:0]   hi_shadow
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W:0] sum;
    logic           sw_load, wrap_zero, advance;

    always_comb begin
        sum       = {1'b0, cnt_q} + (CNT_W+1)'(step);
        sw_load   = lo_wr || hi_wr;
        wrap_zero = running && cmp0_rst_en && cmp0_hit && !sw_load;
        advance   = running && !sw_load && !wrap_zero;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (lo_wr)      cnt_q[HALF_W-1:0] <= wdata;
        else if (hi_wr)      cnt_q[CNT_W-1:HALF_W] <= wdata;
        else if (wrap_zero)  cnt_q <= '0;
        else if (advance)    cnt_q <= sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     ovf_q <= 1'b0;
        else if (advance && sum[CNT_W]) ovf_q <= 1'b1;
        else if (ovf_clr)               ovf_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    hi_shadow <= '0;
        else if (snap) hi_shadow <= cnt_q[CNT_W-1:HALF_W];
    end

    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !lo_wr && !hi_wr) |=> $stable(cnt_q));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> cnt_q == $past(cnt_q) + CNT_W'($past(step)));
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);
    p_wrap_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cmp0_rst_en && cmp0_hit && !lo_wr && !hi_wr) |=> cnt_q == '0);
    p_snap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> hi_shadow == $past(cnt_q[CNT_W-1:HALF_W]));
endmodule

// File: rtl/nstime_counter.sv
module nstime_counter
    import tc_pkg::*;
#(
    parameter int DEF_INC_RST  = 4,
    parameter int COMP_INC_RST = 4,
    parameter int FAST_W       = 24,
    parameter int SLOW_W       = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [REG_DW-1:0]   wr_data,
    input  logic                rd_en,
    output logic [REG_DW-1:0]   rd_data,
    input  logic                cmp0_hit,
    output logic [2*REG_DW-1:0] count,
    output logic                ovf
);
    cfg_t              cfg;
    logic              running;
    logic [FAST_W-1:0] fast_q;
    logic [SLOW_W-1:0] slow_period;
    inc_sel_e          inc_sel;
    logic [COMP_W-1:0] step;
    logic [REG_DW-1:0] hi_shadow;

    tc_ctrl #(.DEF_INC_RST(DEF_INC_RST), .COMP_INC_RST(COMP_INC_RST)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(wr_en && addr == RA_CFG),
        .run_in(wr_data[CFG_RUN_BIT]),
        .def_in(wr_data[CFG_DEF_LSB +: DEF_W]),
        .comp_in(wr_data[CFG_CMP_LSB +: COMP_W]),
        .rst_en_in(wr_data[CFG_RST_BIT]),
        .cfg(cfg), .running(running)
    );

    tc_comp #(.FAST_W(FAST_W), .SLOW_W(SLOW_W)) u_comp (
        .clk(clk), .rst_n(rst_n), .running(running),
        .fast_wr(wr_en && addr == RA_FAST),
        .slow_wr(wr_en && addr == RA_SLOW),
        .wdata(wr_data), .fast_q(fast_q),
        .slow_period(slow_period), .inc_sel(inc_sel)
    );

    always_comb begin
        unique case (inc_sel)
            INC_FAST, INC_SLOW: step = cfg.comp_inc;
            default:            step = {{(COMP_W-DEF_W){1'b0}}, cfg.def_inc};
        endcase
    end

    tc_core #(.HALF_W(REG_DW), .STEP_W(COMP_W)) u_core (
        .clk(clk), .rst_n(rst_n), .running(running), .step(step),
        .cmp0_rst_en(cfg.cmp0_rst), .cmp0_hit(cmp0_hit),
        .lo_wr(wr_en && addr == RA_CNT_LO),
        .hi_wr(wr_en && addr == RA_CNT_HI),
        .wdata(wr_data),
        .ovf_clr(wr_en && addr == RA_STAT && wr_data[0]),
        .snap(rd_en && addr == RA_CNT_LO),
        .cnt_q(count), .ovf_q(ovf), .hi_shadow(hi_shadow)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            RA_CFG: begin
                rd_data[CFG_RUN_BIT]             = cfg.run;
                rd_data[CFG_DEF_LSB +: DEF_W]    = cfg.def_inc;
                rd_data[CFG_CMP_LSB +: COMP_W]   = cfg.comp_inc;
                rd_data[CFG_RST_BIT]             = cfg.cmp0_rst;
            end
            RA_STAT:   rd_data[0] = ovf;
            RA_FAST:   rd_data = REG_DW'(fast_q);
            RA_SLOW:   rd_data = REG_DW'(slow_period);
            RA_CNT_LO: rd_data = count[REG_DW-1:0];
            RA_CNT_HI: rd_data = hi_shadow;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: tb/nstime_counter_tb.sv
`timescale 1ns/1ps
module nstime_counter_tb;
    localparam logic [31:0] CFG_MASK = 32'h010F_FFF1;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, cmp0_hit = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;
    logic [63:0] count;
    logic        ovf;

    always #5 clk = ~clk;

    nstime_counter u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cmp0_hit(cmp0_hit), .count(count), .ovf(ovf)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_cfg, m_slowp, m_slowc, m_shadow;
    logic [63:0] m_cnt;
    logic [23:0] m_fast;
    bit          m_run, m_ovf;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cfg;
            3'd1: return {31'd0, m_ovf};
            3'd2: return {8'd0, m_fast};
            3'd3: return m_slowp;
            3'd4: return m_cnt[31:0];
            3'd5: return m_shadow;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rtag(input logic [2:0] a);
        case (a)
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4, 3'd5: return "R9";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [23:0] clamp24(input logic [31:0] d);
        return (d > 32'h00FF_FFFF) ? 24'hFF_FFFF : d[23:0];
    endfunction

    // one clock: drive at negedge, step the model at the edge, compare at next negedge
    task automatic cyc(input string tag, input bit w = 0, input logic [2:0] a = 0,
                       input logic [31:0] d = 0, input bit r = 0, input bit h = 0);
        logic [11:0] stp;
        logic [64:0] sum;
        bit fast_on, slow_exp, sw, wrap, adv;
        logic [63:0] n_cnt;
        bit n_ovf;
        wr_en = w; addr = a; wr_data = d; rd_en = r; cmp0_hit = h;
        #1;
        if (r) check(rtag(a), {32'd0, rd_data}, {32'd0, model_read(a)});
        fast_on  = m_run && (m_fast != 0);
        slow_exp = m_run && (m_slowp != 0) && (m_slowc <= 1);
        stp = (fast_on || slow_exp) ? m_cfg[19:8] : {8'd0, m_cfg[7:4]};
        sum = {1'b0, m_cnt} + {53'd0, stp};
        sw   = w && (a == 3'd4 || a == 3'd5);
        wrap = m_run && m_cfg[24] && h && !sw;
        adv  = m_run && !sw && !wrap;
        n_cnt = m_cnt;
        if (w && a == 3'd4)      n_cnt[31:0] = d;
        else if (w && a == 3'd5) n_cnt[63:32] = d;
        else if (wrap)           n_cnt = 64'd0;
        else if (adv)            n_cnt = sum[63:0];
        n_ovf = m_ovf;
        if (adv && sum[64])                n_ovf = 1'b1;
        else if (w && a == 3'd1 && d[0])   n_ovf = 1'b0;
        @(posedge clk);
        if (r && a == 3'd4) m_shadow = m_cnt[63:32];
        if (w && a == 3'd2) m_fast = clamp24(d);
        else if (fast_on)   m_fast = m_fast - 24'd1;
        if (w && a == 3'd3) begin
            m_slowp = d; m_slowc = d;
        end else if (m_run && m_slowp != 0) begin
            m_slowc = slow_exp ? m_slowp : m_slowc - 32'd1;
        end
        m_run = m_cfg[0];
        if (w && a == 3'd0) m_cfg = d & CFG_MASK;
        m_cnt = n_cnt;
        m_ovf = n_ovf;
        @(negedge clk);
        check(tag, count, m_cnt);
        check(tag, {63'd0, ovf}, {63'd0, m_ovf});
    endtask

    task automatic idle(input string tag, input int n);
        for (int k = 0; k < n; k++) cyc(tag);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [63:0] c0;
        int unsigned op;
        logic [31:0] rv;
        void'($urandom(32'd20240611));
        m_cfg = 32'h0000_0440; m_run = 0; m_cnt = 0; m_ovf = 0;
        m_fast = 0; m_slowp = 0; m_slowc = 0; m_shadow = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", count, 64'd0);
        check("R1", {63'd0, ovf}, 64'd0);
        check("R1", {32'd0, rd_data}, 64'h440);
        @(negedge clk);
        cyc("R1", 0, 3'd0, 0, 1);

        // R2: two-edge start latency
        cyc("R2", 1, 3'd0, 32'h0000_0441);
        cyc("R2");
        check("R2", count, 64'd0);
        cyc("R2");
        check("R2", count, 64'd4);

        // R5: clamp and budget
        cyc("R5", 1, 3'd2, 32'h1234_5678);
        cyc("R5", 0, 3'd2, 0, 1);
        cyc("R5", 1, 3'd2, 32'd0);
        cyc("R5", 1, 3'd0, 32'h0000_0741);
        c0 = count;
        cyc("R5", 1, 3'd2, 32'd3);
        idle("R5", 5);
        check("R5", count - c0, 64'd4 + 64'd7 * 3 + 64'd4 * 2);

        // R7: slow period zero
        cyc("R7", 1, 3'd3, 32'd0);
        c0 = count;
        idle("R7", 5);
        check("R7", count - c0, 64'd20);

        // R6: slow period three
        cyc("R6", 1, 3'd3, 32'd3);
        c0 = count;
        idle("R6", 6);
        check("R6", count - c0, 64'd30);
        cyc("R6", 0, 3'd3, 0, 1);
        cyc("R7", 1, 3'd3, 32'd0);

        // R8: half writes
        cyc("R8", 1, 3'd4, 32'hFFFF_FFF0);
        cyc("R8", 1, 3'd5, 32'h0000_0001);
        check("R8", {32'd0, count[63:32]}, 64'd1);

        // R9: coherent pair across a carry into the high word
        cyc("R9", 1, 3'd4, 32'hFFFF_FFFC);
        cyc("R9", 0, 3'd4, 0, 1);
        cyc("R9", 0, 3'd5, 0, 1);
        check("R9", count, 64'h0000_0002_0000_0004);

        // R3: overflow, sticky, write-one-to-clear
        cyc("R3", 1, 3'd5, 32'hFFFF_FFFF);
        cyc("R3", 1, 3'd4, 32'hFFFF_FFF8);
        idle("R3", 2);
        check("R3", {63'd0, ovf}, 64'd1);
        check("R3", count, 64'd0);
        cyc("R3", 1, 3'd1, 32'd0);
        check("R3", {63'd0, ovf}, 64'd1);
        cyc("R3", 1, 3'd1, 32'd1);
        check("R3", {63'd0, ovf}, 64'd0);

        // R10: compare reset
        cyc("R10", 1, 3'd0, 32'h0100_0441);
        idle("R10", 3);
        cyc("R10", 0, 3'd0, 0, 0, 1);
        check("R10", count, 64'd0);
        cyc("R10");
        check("R10", count, 64'd4);

        // R11: hit ignored without enable
        cyc("R11", 1, 3'd0, 32'h0000_0441);
        cyc("R11");
        c0 = count;
        cyc("R11", 0, 3'd0, 0, 0, 1);
        check("R11", count, c0 + 64'd4);

        // R2: stop after one more advance
        cyc("R2", 1, 3'd0, 32'h0000_0440);
        cyc("R2");
        c0 = count;
        idle("R2", 3);
        check("R2", count, c0);
        cyc("R4", 1, 3'd0, 32'hFFFF_FFFF);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            op = $urandom_range(0, 15);
            rv = $urandom;
            case (op)
                0: cyc("R4", 1, 3'd0, (rv & CFG_MASK) | {31'd0, rv[30:28] != 3'd0});
                1: cyc("R5", 1, 3'd2, rv[31] ? rv : {29'd0, rv[2:0]});
                2: cyc("R6", 1, 3'd3, {28'd0, rv[3:0]});
                3: cyc("R8", 1, 3'd4, rv);
                4: cyc("R8", 1, 3'd5, rv[0] ? 32'hFFFF_FFFF : rv);
                5: cyc("R3", 1, 3'd1, {31'd0, rv[0]});
                6: cyc("R9", 0, 3'd4, 0, 1);
                7: cyc("R9", 0, 3'd5, 0, 1);
                8: cyc("R4", 0, rv[2:0], 0, 1);
                9: cyc("R10", 0, 3'd0, 0, 0, 1);
                default: cyc("R4", 0, 3'd0, 0, 0, rv[5:3] == 3'd0);
            endcase
        end
        wr_en = 1'b0; rd_en = 1'b0; cmp0_hit = 1'b0;
        finish_run();
    end
endmodule